// File: doc/BRIEF.md
# Latched Parallel-In Serial-Out Shifter

This block pairs a parallel holding register with a serial shift chain. The holding register captures a parallel data word when its own capture strobe rises. The shift chain has a separate step strobe and a serial data input. On each step, data moves one stage toward the most significant stage, and the serial output presents that top stage. Two active-low direct controls act on the chain. One copies the holding register into the chain. The other forces the chain to zero. Both override stepping for as long as they are held.

The capture and step strobes are slow signals sampled by one system clock. Each acts on its rising transition, found by comparing the strobe with its value one clock earlier. The direct controls reach the serial output through a combinational override path, so their effect is visible in the same cycle they are asserted. The chain register itself takes the overridden value at the next system clock edge.

Holding both direct controls low at once is an illegal request. The block flags it on a dedicated output and resolves it by letting the clear control win.

Top module: `latched_piso`

## Requirements
- R1: After synchronous reset, `ser_o` and `invalid_o` are 0, and both the holding register and the chain hold all zeros.
- R2: The holding register takes `din_i` at the system clock edge where `store_clk_i` is 1 and was 0 one clock earlier. Changes on `din_i` at any other time have no effect.
- R3: With both direct controls high, a rising transition of `shift_clk_i` moves every chain stage k to stage k+1. Stage 0 takes `ser_i`. `ser_o` always shows the top stage (bit 7 at the default width).
- R4: With both direct controls high and no rising transition of `shift_clk_i`, the chain keeps its contents.
- R5: While `load_n_i` is 0 and `clear_n_i` is 1, `ser_o` shows the top bit of the holding register in the same cycle. Step transitions are ignored, and the chain keeps the holding register's contents after `load_n_i` returns to 1.
- R6: While `clear_n_i` is 0, `ser_o` is 0 in the same cycle. Step transitions are ignored, and the chain is all zeros after release.
- R7: While both `load_n_i` and `clear_n_i` are 0, `invalid_o` is 1 and clear wins, so the chain is all zeros after both are released.
- R8: A capture transition while `load_n_i` is held 0 carries the new `din_i` into the chain at the same clock edge that captures it.
- R9: A `shift_clk_i` held at 1 for several clocks causes exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | 8 | Parallel data for the holding register |
| store_clk_i | input | 1 | Capture strobe, acts on its rising transition |
| shift_clk_i | input | 1 | Step strobe, acts on its rising transition |
| ser_i | input | 1 | Serial data entering stage 0 |
| load_n_i | input | 1 | Active-low copy of holding register into chain |
| clear_n_i | input | 1 | Active-low clear of the chain |
| ser_o | output | 1 | Top stage of the chain (after override) |
| invalid_o | output | 1 | High while both direct controls are low |

## Verification
The hardest situation to reach is a capture transition that lands while the copy control is already held low. From the ports this is the only way to see new parallel data reach the chain without a separate copy. The bench holds `load_n_i` low, raises the capture strobe with fresh data, then releases the control and shifts all eight bits out. The illegal both-low request is reached the same way: the bench asserts the copy control first and then lowers clear while copy is still held. It then drains the chain to show that clear won.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int unsigned DEF_WIDTH = 8;

    // Which override currently acts on the chain
    typedef enum logic [1:0] {
        OVR_NONE  = 2'd0,
        OVR_LOAD  = 2'd1,
        OVR_CLEAR = 2'd2
    } ovr_e;

    // Index of each strobe inside the edge detector vector
    localparam int unsigned STB_STORE = 0;
    localparam int unsigned STB_SHIFT = 1;
    localparam int unsigned STB_COUNT = 2;

    typedef struct packed {
        logic shift_rise;
        logic store_rise;
    } edges_t;

    // Clear outranks load, so the illegal combination resolves to clear
    function automatic ovr_e pick_override(input logic load_n, input logic clear_n);
        if (!clear_n)     return OVR_CLEAR;
        else if (!load_n) return OVR_LOAD;
        else              return OVR_NONE;
    endfunction

    function automatic logic bad_combo(input logic load_n, input logic clear_n);
        return (!load_n) && (!clear_n);
    endfunction

endpackage

// File: rtl/piso_rise_det.sv
module piso_rise_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    // Previous level resets high so a strobe already high at reset is not an edge
    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= lvl_i;
    end

    for (genvar b = 0; b < N; b++) begin : g_bit
        assign rise_o[b] = lvl_i[b] & ~prev_q[b];
    end
endmodule

// File: rtl/piso_store_reg.sv
module piso_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o
);
    logic [W-1:0] hold_q;

    assign nxt_o = cap_i ? d_i : hold_q;
    assign q_o   = hold_q;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= nxt_o;
    end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_i,
    input  logic         ser_i,
    input  ovr_e         mode_i,
    input  logic [W-1:0] ld_now_i,
    input  logic [W-1:0] ld_next_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] eff_o
);
    logic [W-1:0] chain_q;
    logic [W-1:0] shifted;

    for (genvar s = 0; s < W; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign shifted[s] = ser_i;
        end else begin : g_body
            assign shifted[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            case (mode_i)
                OVR_CLEAR: chain_q <= '0;
                OVR_LOAD:  chain_q <= ld_next_i;
                default:   if (step_i) chain_q <= shifted;
            endcase
        end
    end

    // Direct controls reach the outputs without waiting for a clock
    always_comb begin
        case (mode_i)
            OVR_CLEAR: eff_o = '0;
            OVR_LOAD:  eff_o = ld_now_i;
            default:   eff_o = chain_q;
        endcase
    end

    assign q_o = chain_q;
endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din_i,
    input  logic             store_clk_i,
    input  logic             shift_clk_i,
    input  logic             ser_i,
    input  logic             load_n_i,
    input  logic             clear_n_i,
    output logic             ser_o,
    output logic             invalid_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [STB_COUNT-1:0] strobes;
    logic [STB_COUNT-1:0] rises;
    edges_t               edges;
    ovr_e                 mode;
    logic [WIDTH-1:0]     stor_q;
    logic [WIDTH-1:0]     stor_nxt;
    logic [WIDTH-1:0]     sreg_q;
    logic [WIDTH-1:0]     sreg_eff;

    assign strobes[STB_STORE] = store_clk_i;
    assign strobes[STB_SHIFT] = shift_clk_i;
    assign edges.store_rise   = rises[STB_STORE];
    assign edges.shift_rise   = rises[STB_SHIFT];

    assign mode = pick_override(load_n_i, clear_n_i);

    piso_rise_det #(.N(STB_COUNT)) u_edges (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (strobes),
        .rise_o (rises)
    );

    piso_store_reg #(.W(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .cap_i (edges.store_rise),
        .d_i   (din_i),
        .q_o   (stor_q),
        .nxt_o (stor_nxt)
    );

    piso_shift_reg #(.W(WIDTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .step_i    (edges.shift_rise),
        .ser_i     (ser_i),
        .mode_i    (mode),
        .ld_now_i  (stor_q),
        .ld_next_i (stor_nxt),
        .q_o       (sreg_q),
        .eff_o     (sreg_eff)
    );

    assign ser_o     = sreg_eff[MSB];
    assign invalid_o = bad_combo(load_n_i, clear_n_i);
endmodule

// File: rtl/latched_piso_chk.sv
module latched_piso_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] din_i,
    input logic         store_clk_i,
    input logic         shift_clk_i,
    input logic         ser_i,
    input logic         load_n_i,
    input logic         clear_n_i,
    input logic         ser_o,
    input logic         invalid_o,
    input logic [W-1:0] stor_q,
    input logic [W-1:0] sreg_q
);
    // R2: capture transition stores the parallel word
    p_store_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && store_clk_i && !$past(store_clk_i)) |=> (stor_q == $past(din_i)));

    // R3: a step moves data one stage up and takes the serial bit at stage 0
    p_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && load_n_i && clear_n_i && shift_clk_i && !$past(shift_clk_i))
        |=> (sreg_q == {$past(sreg_q[W-2:0]), $past(ser_i)}));

    // R4: no step and no override keeps the chain
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && load_n_i && clear_n_i && !(shift_clk_i && !$past(shift_clk_i)))
        |=> $stable(sreg_q));

    // R5: copy override shows the holding register top bit at once
    p_load_view_r5: assert property (@(posedge clk) disable iff (rst)
        (!load_n_i && clear_n_i) |-> (ser_o == stor_q[W-1]));

    // R6: clear override forces the output low at once
    p_clear_view_r6: assert property (@(posedge clk) disable iff (rst)
        !clear_n_i |-> !ser_o);

    // R7: illegal request leaves an all-zero chain
    p_invalid_zero_r7: assert property (@(posedge clk) disable iff (rst)
        invalid_o |=> (sreg_q == '0));
endmodule

bind latched_piso latched_piso_chk #(.W(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .din_i       (din_i),
    .store_clk_i (store_clk_i),
    .shift_clk_i (shift_clk_i),
    .ser_i       (ser_i),
    .load_n_i    (load_n_i),
    .clear_n_i   (clear_n_i),
    .ser_o       (ser_o),
    .invalid_o   (invalid_o),
    .stor_q      (stor_q),
    .sreg_q      (sreg_q)
);

// File: tb/test_latched_piso.sv
module test_latched_piso;
    localparam int PERIOD = 10;
    localparam int W      = 8;

    // Table ops: 0 store data, 1 copy pulse, 2 clear pulse, 3 step with data[0], 4 drain 8 bits
    localparam int NVEC = 16;
    localparam logic [10:0] VEC [0:NVEC-1] = '{
        {3'd0, 8'hA5}, {3'd1, 8'h00}, {3'd4, 8'h00}, {3'd0, 8'h3C},
        {3'd3, 8'h01}, {3'd1, 8'h00}, {3'd3, 8'h00}, {3'd3, 8'h01},
        {3'd4, 8'h00}, {3'd3, 8'h01}, {3'd2, 8'h00}, {3'd3, 8'h01},
        {3'd0, 8'hF0}, {3'd1, 8'h00}, {3'd3, 8'h00}, {3'd4, 8'h00}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din_i = '0;
    logic         store_clk_i = 1'b0;
    logic         shift_clk_i = 1'b0;
    logic         ser_i = 1'b0;
    logic         load_n_i = 1'b1;
    logic         clear_n_i = 1'b1;
    logic         ser_o;
    logic         invalid_o;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] stor_m = '0;
    logic [W-1:0] sreg_m = '0;

    always #(PERIOD/2) clk = ~clk;

    latched_piso #(.WIDTH(W)) i_latched_piso (
        .clk         (clk),
        .rst         (rst),
        .din_i       (din_i),
        .store_clk_i (store_clk_i),
        .shift_clk_i (shift_clk_i),
        .ser_i       (ser_i),
        .load_n_i    (load_n_i),
        .clear_n_i   (clear_n_i),
        .ser_o       (ser_o),
        .invalid_o   (invalid_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [W-1:0] d);
        din_i = d;
        store_clk_i = 1'b1;
        @(negedge clk);
        store_clk_i = 1'b0;
        stor_m = d;
        if (!load_n_i && clear_n_i) sreg_m = d;
        @(negedge clk);
    endtask

    task automatic do_shift(input logic b);
        ser_i = b;
        shift_clk_i = 1'b1;
        @(negedge clk);
        shift_clk_i = 1'b0;
        if (load_n_i && clear_n_i) sreg_m = {sreg_m[W-2:0], b};
        @(negedge clk);
    endtask

    task automatic do_load();
        load_n_i = 1'b0;
        #1 chk("R5 same-cycle copy view", ser_o, stor_m[W-1]);
        @(negedge clk);
        load_n_i = 1'b1;
        sreg_m = stor_m;
        @(negedge clk);
    endtask

    task automatic do_clear();
        clear_n_i = 1'b0;
        #1 chk("R6 same-cycle clear view", ser_o, 1'b0);
        @(negedge clk);
        clear_n_i = 1'b1;
        sreg_m = '0;
        @(negedge clk);
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < W; i++) begin
            chk(req, ser_o, sreg_m[W-1]);
            do_shift(1'b0);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 ser_o after reset", ser_o, 1'b0);
        chk("R1 invalid_o after reset", invalid_o, 1'b0);
        drain("R1 chain zero after reset");
        do_load();
        drain("R1 holding register zero after reset");

        // Table walk against the reference model (R2, R3, R5, R6)
        for (int v = 0; v < NVEC; v++) begin
            case (VEC[v][10:8])
                3'd0: do_store(VEC[v][7:0]);
                3'd1: do_load();
                3'd2: do_clear();
                3'd3: do_shift(VEC[v][0]);
                default: drain("R3 table drain");
            endcase
            chk("R3 table step output", ser_o, sreg_m[W-1]);
        end

        // R2: din changes without a capture transition are ignored
        do_store(8'h96);
        din_i = 8'h0F;
        repeat (3) @(negedge clk);
        do_load();
        drain("R2 din ignored without capture edge");

        // R4: idle cycles hold contents
        do_store(8'hC3);
        do_load();
        repeat (5) begin
            @(negedge clk);
            chk("R4 hold without step", ser_o, 1'b1);
        end
        drain("R4 contents kept while idle");

        // R9: a strobe held high steps only once
        ser_i = 1'b1;
        shift_clk_i = 1'b1;
        repeat (4) @(negedge clk);
        shift_clk_i = 1'b0;
        sreg_m = {sreg_m[W-2:0], 1'b1};
        @(negedge clk);
        drain("R9 single step for held strobe");

        // R5: steps ignored during copy override
        do_store(8'h5A);
        load_n_i = 1'b0;
        do_shift(1'b1);
        do_shift(1'b0);
        chk("R5 view held during copy", ser_o, 1'b0);
        load_n_i = 1'b1;
        sreg_m = stor_m;
        @(negedge clk);
        drain("R5 chain equals holding register");

        // R6: steps ignored during clear
        do_store(8'hFF);
        do_load();
        clear_n_i = 1'b0;
        do_shift(1'b1);
        chk("R6 output low while clear held", ser_o, 1'b0);
        clear_n_i = 1'b1;
        sreg_m = '0;
        @(negedge clk);
        drain("R6 chain zero after clear");

        // R7: both low is flagged and clear wins
        do_store(8'hE7);
        load_n_i = 1'b0;
        @(negedge clk);
        clear_n_i = 1'b0;
        #1 chk("R7 invalid flag raised", invalid_o, 1'b1);
        chk("R7 clear wins on output", ser_o, 1'b0);
        @(negedge clk);
        load_n_i = 1'b1;
        clear_n_i = 1'b1;
        sreg_m = '0;
        #1 chk("R7 invalid flag dropped", invalid_o, 1'b0);
        @(negedge clk);
        drain("R7 chain zero after invalid request");

        // R8: capture during a held copy flows into the chain
        do_store(8'h11);
        load_n_i = 1'b0;
        @(negedge clk);
        do_store(8'hB4);
        chk("R8 new data top bit visible", ser_o, 1'b1);
        load_n_i = 1'b1;
        @(negedge clk);
        drain("R8 chain holds flowed-through data");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule